// File: doc/BRIEF.md
# Command Queue Error Capture Unit

This block sits inside the command queueing engine of a storage host controller and decides what happens when something goes wrong. The command path, data path, DMA and bus master each raise a one-cycle error strobe. The strobe carries an error code, the kind of operation in flight and the task ID it belongs to. On a recoverable error the unit halts the queue and sets a sticky status bit for the error type. It also records which task failed, and in which phase, in a task error record. That record has separate task-ID slots for queueing-phase failures and execution-phase failures.

Halting and resuming use a handshake with the command and data paths. A halt can be entered by an error or by software. The acknowledge rises only once both paths have reported that they finished or aborted. Software then clears the halt with a resume strobe, and the next error can update the record again. Status-poll (CMD13) errors halt the queue without naming a task. Poll errors raised while a data transfer is running go to a separate 4-bit field. A current-limit condition is only reported and never stops the queue. An interrupt is raised when a status bit is set and its signal enable is on.

Top module: `cq_err_capture`

## Requirements
- R1: A strobe with `err_valid` high, `cq_en` high and `err_code` from 0 to 9 sets `halted` at the next clock edge. The codes are: 0 R1 response, 1 command timeout, 2 command CRC, 3 command end bit, 4 command index, 5 data timeout, 6 data CRC, 7 data end bit, 8 DMA, 9 bus manager. Codes 10 to 15 cause no halt.
- R2: `status[k]` for code k sets one cycle after a recoverable strobe only while `stat_en[k]` is high, and it stays set while halted. A bit is cleared by a one in `clr_mask`, and a set in the same cycle wins over the clear.
- R3: `err_op` encodings 0 (fetch before CMD44), 2 (fetch before direct command), 3 (CMD44), 4 (CMD45) and 6 (direct command, including its data timeout) set `resp_mode_err`, clear `data_xfer_err` and load `task_id_resp` with `err_task`. The two flags are never both high.
- R4: `err_op` encodings 1 (fetch before CMD46/CMD47) and 5 (CMD46/CMD47) set `data_xfer_err`, clear `resp_mode_err` and load `task_id_data`. The other task-ID slot keeps its value.
- R5: An error with `err_op` 7 (CMD13 status poll) halts the queue, and the task error record does not change.
- R6: A poll error (op 7) with `poll_concurrent` high and code 1 to 4 sets `auto_cmd_err[code-1]` instead of `status[code]`. An accepted resume clears `auto_cmd_err`.
- R7: The task error record changes only for the first recoverable error after a resume. It holds while `halted` is high or `cq_en` is low.
- R8: `halt_req` with `cq_en` high sets `halted`. `halt_ack` rises only after both `cmd_done` and `dat_done` have been seen while halted, in either order or together.
- R9: `resume` has no effect before `halt_ack`. Once `halt_ack` is high, `resume` clears `halted` and `halt_ack` at the next edge.
- R10: `cur_lim` sets `status[10]` when `stat_en[10]` is high and never halts the queue.
- R11: An R1 response error (code 0) also sets `status[11]`. `irq` is high whenever any `status[k]` and `sig_en[k]` are both high.
- R12: After reset, `halted`, `halt_ack`, `status`, `auto_cmd_err`, `irq` and the whole task error record are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cq_en | input | 1 | Command queueing enabled |
| err_valid | input | 1 | Error strobe |
| err_op | input | 3 | Operation in flight when the error occurred |
| err_code | input | 4 | Error type code |
| err_task | input | TASK_W | Task ID of the failing operation |
| poll_concurrent | input | 1 | Poll ran alongside a data transfer |
| cur_lim | input | 1 | Current-limit condition |
| halt_req | input | 1 | Software halt request |
| cmd_done | input | 1 | Command path reports completion or abort |
| dat_done | input | 1 | Data path reports completion or abort |
| resume | input | 1 | Software clears the halt |
| stat_en | input | 12 | Per-bit status enable |
| sig_en | input | 12 | Per-bit interrupt signal enable |
| clr_mask | input | 12 | Write-one-to-clear mask for status |
| halted | output | 1 | Queue halted |
| halt_ack | output | 1 | Halt acknowledge |
| status | output | 12 | Sticky error status |
| auto_cmd_err | output | 4 | Concurrent poll command error bits |
| resp_mode_err | output | 1 | Record: response-mode error |
| data_xfer_err | output | 1 | Record: data-transfer error |
| task_id_resp | output | TASK_W | Record: task ID of response-mode error |
| task_id_data | output | TASK_W | Record: task ID of data-transfer error |
| irq | output | 1 | Error interrupt |

## Verification
The bench builds the unit with the default TASK_W of 5, so task IDs run from 0 to 31. This lets the top slot 31 and slot 0 both appear in the record. The 4-bit error code leaves six unused values, so an out-of-range code can be driven and shown to cause no halt. The 12-bit enable vectors can be switched bit by bit, which makes it possible to separate status gating, signal gating and the response-error bit's own enable pair.

// File: rtl/cq_err_pkg.sv
package cq_err_pkg;
    localparam int unsigned NUM_CODES   = 10;
    localparam int unsigned CODE_W      = 4;
    localparam int unsigned STAT_W      = NUM_CODES + 2;
    localparam int unsigned BIT_CURLIM  = NUM_CODES;
    localparam int unsigned BIT_RESPDET = NUM_CODES + 1;
    localparam int unsigned AUTO_W      = 4;
    localparam int unsigned AUTO_BASE   = 1;

    typedef enum logic [2:0] {
        OP_FETCH_QUEUE = 3'd0,
        OP_FETCH_EXEC  = 3'd1,
        OP_FETCH_DCMD  = 3'd2,
        OP_QUEUE       = 3'd3,
        OP_ADDR        = 3'd4,
        OP_EXEC        = 3'd5,
        OP_DCMD        = 3'd6,
        OP_POLL        = 3'd7
    } cq_op_e;
endpackage

// File: rtl/cq_err_decode.sv
module cq_err_decode
    import cq_err_pkg::*;
(
    input  logic                 err_valid,
    input  logic [2:0]           err_op,
    input  logic [CODE_W-1:0]    err_code,
    input  logic                 poll_concurrent,
    output logic                 recoverable,
    output logic                 log_task,
    output logic                 to_data,
    output logic [NUM_CODES-1:0] code_hit,
    output logic [AUTO_W-1:0]    auto_hit
);
    cq_op_e op;
    logic   in_range;
    logic   auto_case;

    always_comb begin
        op          = cq_op_e'(err_op);
        in_range    = err_code < CODE_W'(NUM_CODES);
        recoverable = err_valid && in_range;
        log_task    = recoverable && (op != OP_POLL);
        to_data     = (op == OP_FETCH_EXEC) || (op == OP_EXEC);
        auto_case   = err_valid && (op == OP_POLL) && poll_concurrent &&
                      (err_code >= CODE_W'(AUTO_BASE)) &&
                      (err_code <  CODE_W'(AUTO_BASE + AUTO_W));
    end

    // one status line per recoverable error code
    for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
        assign code_hit[k] = err_valid && !auto_case && (err_code == CODE_W'(k));
    end

    // concurrent poll command errors are diverted into their own field
    for (genvar i = 0; i < AUTO_W; i++) begin : g_auto
        assign auto_hit[i] = auto_case && (err_code == CODE_W'(i + AUTO_BASE));
    end
endmodule

// File: rtl/cq_halt_ctrl.sv
module cq_halt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic cmd_done,
    input  logic dat_done,
    input  logic resume,
    output logic halted,
    output logic halt_ack
);
    typedef struct packed {
        logic halted;
        logic cmd_seen;
        logic dat_seen;
        logic ack;
    } halt_t;

    halt_t st_d, st_q;
    logic  cmd_now, dat_now;

    always_comb begin
        st_d    = st_q;
        cmd_now = st_q.cmd_seen || cmd_done;
        dat_now = st_q.dat_seen || dat_done;
        if (!st_q.halted) begin
            if (enter) begin
                st_d.halted   = 1'b1;
                st_d.cmd_seen = 1'b0;
                st_d.dat_seen = 1'b0;
                st_d.ack      = 1'b0;
            end
        end else if (st_q.ack) begin
            if (resume) begin
                st_d = '0;
            end
        end else begin
            st_d.cmd_seen = cmd_now;
            st_d.dat_seen = dat_now;
            st_d.ack      = cmd_now && dat_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign halted   = st_q.halted;
    assign halt_ack = st_q.ack;
endmodule

// File: rtl/cq_task_record.sv
module cq_task_record #(
    parameter int unsigned TASK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              to_data,
    input  logic [TASK_W-1:0] task_id,
    output logic              resp_flag,
    output logic              data_flag,
    output logic [TASK_W-1:0] tid_resp,
    output logic [TASK_W-1:0] tid_data
);
    typedef struct packed {
        logic              resp;
        logic              data;
        logic [TASK_W-1:0] tid_r;
        logic [TASK_W-1:0] tid_d;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (capture) begin
            rec_d.resp = !to_data;
            rec_d.data = to_data;
            if (to_data) rec_d.tid_d = task_id;
            else         rec_d.tid_r = task_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign resp_flag = rec_q.resp;
    assign data_flag = rec_q.data;
    assign tid_resp  = rec_q.tid_r;
    assign tid_data  = rec_q.tid_d;
endmodule

// File: rtl/cq_err_capture.sv
module cq_err_capture
    import cq_err_pkg::*;
#(
    parameter int unsigned TASK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cq_en,
    input  logic              err_valid,
    input  logic [2:0]        err_op,
    input  logic [3:0]        err_code,
    input  logic [TASK_W-1:0] err_task,
    input  logic              poll_concurrent,
    input  logic              cur_lim,
    input  logic              halt_req,
    input  logic              cmd_done,
    input  logic              dat_done,
    input  logic              resume,
    input  logic [11:0]       stat_en,
    input  logic [11:0]       sig_en,
    input  logic [11:0]       clr_mask,
    output logic              halted,
    output logic              halt_ack,
    output logic [11:0]       status,
    output logic [3:0]        auto_cmd_err,
    output logic              resp_mode_err,
    output logic              data_xfer_err,
    output logic [TASK_W-1:0] task_id_resp,
    output logic [TASK_W-1:0] task_id_data,
    output logic              irq
);
    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [AUTO_W-1:0] auto_err;
    } regs_t;

    regs_t r_d, r_q;

    logic                 recoverable, log_task, to_data;
    logic [NUM_CODES-1:0] code_hit;
    logic [AUTO_W-1:0]    auto_hit;
    logic                 halt_enter, capture, resume_ok;
    logic [STAT_W-1:0]    set_vec;

    cq_err_decode u_decode (
        .err_valid       (err_valid),
        .err_op          (err_op),
        .err_code        (err_code),
        .poll_concurrent (poll_concurrent),
        .recoverable     (recoverable),
        .log_task        (log_task),
        .to_data         (to_data),
        .code_hit        (code_hit),
        .auto_hit        (auto_hit)
    );

    assign halt_enter = cq_en && (recoverable || halt_req);

    cq_halt_ctrl u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter    (halt_enter),
        .cmd_done (cmd_done),
        .dat_done (dat_done),
        .resume   (resume),
        .halted   (halted),
        .halt_ack (halt_ack)
    );

    assign capture = cq_en && log_task && !halted;

    cq_task_record #(.TASK_W(TASK_W)) u_record (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .to_data   (to_data),
        .task_id   (err_task),
        .resp_flag (resp_mode_err),
        .data_flag (data_xfer_err),
        .tid_resp  (task_id_resp),
        .tid_data  (task_id_data)
    );

    always_comb begin
        r_d       = r_q;
        resume_ok = halted && halt_ack && resume;
        set_vec   = '0;
        set_vec[NUM_CODES-1:0] = code_hit & {NUM_CODES{cq_en}};
        set_vec[BIT_CURLIM]    = cur_lim;
        set_vec[BIT_RESPDET]   = cq_en && code_hit[0];
        r_d.stat     = (r_q.stat & ~clr_mask) | (set_vec & stat_en);
        r_d.auto_err = resume_ok ? '0 : (r_q.auto_err | (auto_hit & {AUTO_W{cq_en}}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status       = r_q.stat;
    assign auto_cmd_err = r_q.auto_err;
    assign irq          = |(r_q.stat & sig_en);
endmodule

// File: rtl/cq_err_checker.sv
module cq_err_checker
    import cq_err_pkg::*;
#(
    parameter int unsigned TASK_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cq_en,
    input logic              err_valid,
    input logic [2:0]        err_op,
    input logic [3:0]        err_code,
    input logic              halt_req,
    input logic              halted,
    input logic              halt_ack,
    input logic              resp_mode_err,
    input logic              data_xfer_err,
    input logic [TASK_W-1:0] task_id_resp,
    input logic [TASK_W-1:0] task_id_data
);
    logic [2*TASK_W+1:0] rec;
    assign rec = {resp_mode_err, data_xfer_err, task_id_resp, task_id_data};

    assert_err_halts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cq_en && err_valid && (err_code < CODE_W'(NUM_CODES))) |=> halted);

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_mode_err && data_xfer_err));

    assert_poll_keeps_record_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && (err_op == 3'd7)) |=> $stable(rec));

    assert_frozen_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(rec));

    assert_frozen_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cq_en |=> $stable(rec));

    assert_ack_only_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_ack |-> halted);

    assert_resume_waits_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !halt_ack) |=> halted);

    assert_no_stray_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !(cq_en && (err_valid || halt_req))) |=> !halted);
endmodule

bind cq_err_capture cq_err_checker #(.TASK_W(TASK_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cq_en         (cq_en),
    .err_valid     (err_valid),
    .err_op        (err_op),
    .err_code      (err_code),
    .halt_req      (halt_req),
    .halted        (halted),
    .halt_ack      (halt_ack),
    .resp_mode_err (resp_mode_err),
    .data_xfer_err (data_xfer_err),
    .task_id_resp  (task_id_resp),
    .task_id_data  (task_id_data)
);

// File: tb/sim_cq_err_capture.sv
`timescale 1ns/1ps
module sim_cq_err_capture;
    localparam int TW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cq_en, err_valid, poll_concurrent, cur_lim, halt_req;
    logic          cmd_done, dat_done, resume;
    logic [2:0]    err_op;
    logic [3:0]    err_code;
    logic [TW-1:0] err_task;
    logic [11:0]   stat_en, sig_en, clr_mask;
    logic          halted, halt_ack, resp_mode_err, data_xfer_err, irq;
    logic [11:0]   status;
    logic [3:0]    auto_cmd_err;
    logic [TW-1:0] task_id_resp, task_id_data;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cq_err_capture #(.TASK_W(TW)) u0 (.*);

    // op, code, task, concurrent | exp resp, exp data, exp tid_resp, exp tid_data
    localparam logic [24:0] VEC [10] = '{
        {3'd3, 4'd2, 5'd5,  1'b0, 1'b1, 1'b0, 5'd5,  5'd0},
        {3'd5, 4'd6, 5'd9,  1'b0, 1'b0, 1'b1, 5'd5,  5'd9},
        {3'd6, 4'd5, 5'd12, 1'b0, 1'b1, 1'b0, 5'd12, 5'd9},
        {3'd1, 4'd9, 5'd3,  1'b0, 1'b0, 1'b1, 5'd12, 5'd3},
        {3'd7, 4'd1, 5'd20, 1'b0, 1'b0, 1'b1, 5'd12, 5'd3},
        {3'd4, 4'd0, 5'd31, 1'b0, 1'b1, 1'b0, 5'd31, 5'd3},
        {3'd0, 4'd9, 5'd7,  1'b0, 1'b1, 1'b0, 5'd7,  5'd3},
        {3'd5, 4'd8, 5'd17, 1'b0, 1'b0, 1'b1, 5'd7,  5'd17},
        {3'd2, 4'd9, 5'd2,  1'b0, 1'b1, 1'b0, 5'd2,  5'd17},
        {3'd7, 4'd3, 5'd4,  1'b1, 1'b1, 1'b0, 5'd2,  5'd17}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic fire(input logic [2:0] op, input logic [3:0] code,
                        input logic [TW-1:0] tid, input logic conc);
        err_valid = 1'b1; err_op = op; err_code = code;
        err_task = tid; poll_concurrent = conc;
        @(negedge clk);
        err_valid = 1'b0; poll_concurrent = 1'b0;
    endtask

    task automatic recover();
        cmd_done = 1'b1; dat_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0; dat_done = 1'b0;
        chk("R8 ack after both paths", 32'(halt_ack), 32'd1);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        chk("R9 resume clears halt", 32'(halted), 32'd0);
    endtask

    task automatic clr_all();
        clr_mask = '1;
        @(negedge clk);
        clr_mask = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL R12 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cq_en = 1'b1; err_valid = 1'b0; poll_concurrent = 1'b0;
        cur_lim = 1'b0; halt_req = 1'b0; cmd_done = 1'b0; dat_done = 1'b0;
        resume = 1'b0; err_op = '0; err_code = '0; err_task = '0;
        stat_en = '1; sig_en = '0; clr_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        chk("R12 halted", 32'(halted), 32'd0);
        chk("R12 halt_ack", 32'(halt_ack), 32'd0);
        chk("R12 status", 32'(status), 32'd0);
        chk("R12 auto", 32'(auto_cmd_err), 32'd0);
        chk("R12 irq", 32'(irq), 32'd0);
        chk("R12 record", {resp_mode_err, data_xfer_err, task_id_resp, task_id_data}, 32'd0);

        for (int i = 0; i < 10; i++) begin
            logic [24:0] v;
            string tag;
            v = VEC[i];
            tag = (v[24:22] == 3'd7) ? "R5" : (v[10] ? "R4" : "R3");
            fire(v[24:22], v[21:18], v[17:13], v[12]);
            chk("R1 error halts", 32'(halted), 32'd1);
            chk({tag, " resp flag"}, 32'(resp_mode_err), 32'(v[11]));
            chk({tag, " data flag"}, 32'(data_xfer_err), 32'(v[10]));
            chk({tag, " tid_resp"}, 32'(task_id_resp), 32'(v[9:5]));
            chk({tag, " tid_data"}, 32'(task_id_data), 32'(v[4:0]));
            recover();
        end

        clr_all();
        // R7 only the first error is recorded
        fire(3'd5, 4'd6, 5'd11, 1'b0);
        fire(3'd3, 4'd2, 5'd22, 1'b0);
        chk("R7 first error kept data", 32'(data_xfer_err), 32'd1);
        chk("R7 first error kept tid", 32'(task_id_data), 32'd11);
        chk("R7 resp flag stays clear", 32'(resp_mode_err), 32'd0);
        chk("R2 sticky while halted", 32'(status[2] & status[6]), 32'd1);
        recover();

        // R7 disabled queue ignores errors
        cq_en = 1'b0;
        fire(3'd3, 4'd2, 5'd30, 1'b0);
        chk("R7 disabled no halt", 32'(halted), 32'd0);
        chk("R7 disabled record", {resp_mode_err, data_xfer_err, task_id_data}, {25'd0, 1'b0, 1'b1, 5'd11});
        cq_en = 1'b1;

        // R1 out-of-range code
        fire(3'd3, 4'd12, 5'd3, 1'b0);
        chk("R1 code 12 no halt", 32'(halted), 32'd0);
        chk("R1 code 12 no record", 32'(task_id_resp), 32'd2);

        // R10 current limit
        clr_all();
        cur_lim = 1'b1;
        @(negedge clk);
        cur_lim = 1'b0;
        chk("R10 curlim status", 32'(status[10]), 32'd1);
        chk("R10 curlim no halt", 32'(halted), 32'd0);

        // R2 write-one-to-clear and status enable
        clr_mask = 12'h400;
        @(negedge clk);
        clr_mask = '0;
        chk("R2 w1c clears", 32'(status[10]), 32'd0);
        stat_en[6] = 1'b0;
        fire(3'd5, 4'd6, 5'd1, 1'b0);
        chk("R2 disabled bit stays clear", 32'(status[6]), 32'd0);
        chk("R1 halts even unlogged", 32'(halted), 32'd1);
        recover();
        stat_en = '1;

        // R11 interrupt and response-detected bit
        clr_all();
        fire(3'd4, 4'd0, 5'd4, 1'b0);
        chk("R11 r1 bits", 32'(status & 12'h801), 32'h801);
        chk("R11 no irq without signal enable", 32'(irq), 32'd0);
        sig_en = 12'h800;
        #1;
        chk("R11 irq via resp-detect pair", 32'(irq), 32'd1);
        sig_en = 12'h001;
        #1;
        chk("R11 irq via code bit", 32'(irq), 32'd1);
        @(negedge clk);
        clr_mask = 12'h801;
        @(negedge clk);
        clr_mask = '0;
        chk("R11 irq drops after clear", 32'(irq), 32'd0);
        sig_en = '0;
        recover();

        // R6 concurrent poll error field
        clr_all();
        fire(3'd7, 4'd2, 5'd9, 1'b1);
        chk("R6 auto bit", 32'(auto_cmd_err), 32'h2);
        chk("R6 main status untouched", 32'(status[2]), 32'd0);
        chk("R5 poll halts", 32'(halted), 32'd1);
        chk("R5 poll keeps tid", 32'(task_id_resp), 32'd4);
        recover();
        chk("R6 resume clears auto", 32'(auto_cmd_err), 32'd0);

        // R8 / R9 handshake ordering
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        chk("R8 halt_req halts", 32'(halted), 32'd1);
        chk("R8 no ack yet", 32'(halt_ack), 32'd0);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        chk("R9 early resume ignored", 32'(halted), 32'd1);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        chk("R8 cmd only no ack", 32'(halt_ack), 32'd0);
        dat_done = 1'b1;
        @(negedge clk);
        dat_done = 1'b0;
        chk("R8 both seen ack", 32'(halt_ack), 32'd1);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        chk("R9 resume after ack", 32'(halted | halt_ack), 32'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule